// File: doc/BRIEF.md
# Rotating Register File with Base-Relative Renaming

This block is a register file for software-pipelined loops. Its storage is split into two regions. The low part of the logical specifier space is the rotating region. Every access to it is shifted by a run-time base value, and the sum wraps around the size of that region. The specifiers above the rotating region name fixed registers, which are used unchanged. Specifiers past the end of the file name nothing.

A loop-closing branch pulses the rotate strobe, which lowers the base by one (wrapping from zero to the top of the region). Because of this, a value written to logical register N in one iteration is found at logical register N+1 in the next iteration. The compiler can therefore express a latency of k iterations as a specifier distance of k. Software can also load the base directly, for example to start a new loop.

The file has two combinational read ports and one write port. A read that hits the register being written in the same cycle sees the new data.

Top module: `rotating_regfile`

## Requirements
- R1: After reset the base is zero and every register in both regions reads as zero.
- R2: A specifier s below ROT_REGS reaches physical rotating register (s + base) mod ROT_REGS, on both read ports and on the write port.
- R3: A specifier s with ROT_REGS <= s < ROT_REGS+STAT_REGS reaches the same fixed register whatever the base. Its contents are not moved by rotation.
- R4: A cycle with `rot_step` high and `base_load` low lowers the base by one, and a base of 0 becomes ROT_REGS-1. As a result, data written at logical s before the step reads back at logical (s+1) mod ROT_REGS after it.
- R5: Reads and writes issued in the same cycle as a rotate step or a base load are translated with the base value from before that cycle's edge.
- R6: When a read port and the enabled write port reach the same physical register in one cycle, the read port returns `wr_data` in that cycle (write-first).
- R7: A cycle with `base_load` high sets the base to `base_value` mod ROT_REGS, and it takes priority over `rot_step` in the same cycle. With neither strobe high, the base holds.
- R8: A specifier at or above ROT_REGS+STAT_REGS reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_spec | input | SPEC_W | Logical specifier, read port 0 |
| rd0_data | output | DATA_W | Read data, port 0 (combinational) |
| rd1_spec | input | SPEC_W | Logical specifier, read port 1 |
| rd1_data | output | DATA_W | Read data, port 1 (combinational) |
| wr_en | input | 1 | Write enable |
| wr_spec | input | SPEC_W | Logical specifier, write port |
| wr_data | input | DATA_W | Write data |
| rot_step | input | 1 | Loop-branch strobe: lower the base by one |
| base_load | input | 1 | Load the base from `base_value` |
| base_value | input | ROT_W | New base value |

## Verification
A wrong base value shows up at the ports only through data. A rotating-region read returns a neighbour's contents from the first cycle the base is off, while fixed-region reads stay correct. This makes the fixed region a control that separates a translation fault from a storage fault. A wrong wrap on the step or on the add only appears when the base passes zero or when a specifier plus the base crosses ROT_REGS, so the stimulus drives both crossings on purpose. A bypass fault appears only in the cycle of a colliding write, and is gone one cycle later when the stored value catches up.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    typedef enum logic [1:0] {
        BASE_HOLD = 2'd0,
        BASE_STEP = 2'd1,
        BASE_LOAD = 2'd2
    } base_cmd_e;

    // modulo add of two values already below m
    function automatic logic [31:0] wrap_add(input logic [31:0] a,
                                             input logic [31:0] b,
                                             input logic [31:0] m);
        logic [31:0] s;
        s = a + b;
        return (s >= m) ? (s - m) : s;
    endfunction

    // modulo decrement of a value already below m
    function automatic logic [31:0] wrap_dec(input logic [31:0] a,
                                             input logic [31:0] m);
        return (a == 32'd0) ? (m - 32'd1) : (a - 32'd1);
    endfunction

endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl #(
    parameter int ROT_REGS = 16,
    parameter int ROT_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  rrf_pkg::base_cmd_e   cmd,
    input  logic [ROT_W-1:0]     load_val,
    output logic [ROT_W-1:0]     base
);
    typedef struct packed {
        logic [ROT_W-1:0] base;
    } base_state_t;

    base_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd)
            rrf_pkg::BASE_LOAD:
                st_d.base = ROT_W'(32'(load_val) % 32'(ROT_REGS));
            rrf_pkg::BASE_STEP:
                st_d.base = ROT_W'(rrf_pkg::wrap_dec(32'(st_q.base), 32'(ROT_REGS)));
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base = st_q.base;
endmodule

// File: rtl/rrf_xlate.sv
module rrf_xlate #(
    parameter int ROT_REGS   = 16,
    parameter int TOTAL_REGS = 24,
    parameter int SPEC_W     = 5,
    parameter int PHYS_W     = 5,
    parameter int ROT_W      = 4
) (
    input  logic [SPEC_W-1:0] spec,
    input  logic [ROT_W-1:0]  base,
    output logic [PHYS_W-1:0] phys,
    output logic              hit
);
    logic [31:0] spec_x;
    logic [31:0] base_x;

    always_comb begin
        spec_x = 32'(spec);
        base_x = 32'(base);
        hit    = (spec_x < 32'(TOTAL_REGS));
        if (!hit) begin
            phys = '0;
        end else if (spec_x < 32'(ROT_REGS)) begin
            phys = PHYS_W'(rrf_pkg::wrap_add(spec_x, base_x, 32'(ROT_REGS)));
        end else begin
            phys = PHYS_W'(spec_x);
        end
    end
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
    parameter int DATA_W   = 16,
    parameter int NUM_PHYS = 24,
    parameter int PHYS_W   = 5,
    parameter int NUM_RD   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [PHYS_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [NUM_RD-1:0]                 rd_en,
    input  logic [NUM_RD-1:0][PHYS_W-1:0]     rd_addr,
    output logic [NUM_RD-1:0][DATA_W-1:0]     rd_data
);
    typedef struct packed {
        logic [NUM_PHYS-1:0][DATA_W-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.regs[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        always_comb begin
            if (!rd_en[g]) begin
                rd_data[g] = '0;
            end else if (wr_en && (wr_addr == rd_addr[g])) begin
                rd_data[g] = wr_data;
            end else begin
                rd_data[g] = st_q.regs[rd_addr[g]];
            end
        end
    end
endmodule

// File: rtl/rotating_regfile.sv
module rotating_regfile #(
    parameter int DATA_W    = 16,
    parameter int ROT_REGS  = 16,
    parameter int STAT_REGS = 8,
    parameter int SPEC_W    = 5,
    parameter int ROT_W     = $clog2(ROT_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SPEC_W-1:0] rd0_spec,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [SPEC_W-1:0] rd1_spec,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [SPEC_W-1:0] wr_spec,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rot_step,
    input  logic              base_load,
    input  logic [ROT_W-1:0]  base_value
);
    localparam int TOTAL_REGS = ROT_REGS + STAT_REGS;
    localparam int PHYS_W     = $clog2(TOTAL_REGS);
    localparam int NUM_RD     = 2;
    localparam int NUM_XL     = NUM_RD + 1;

    rrf_pkg::base_cmd_e cmd;
    logic [ROT_W-1:0]   base_q;

    always_comb begin
        if (base_load)     cmd = rrf_pkg::BASE_LOAD;
        else if (rot_step) cmd = rrf_pkg::BASE_STEP;
        else               cmd = rrf_pkg::BASE_HOLD;
    end

    rrf_base_ctrl #(
        .ROT_REGS (ROT_REGS),
        .ROT_W    (ROT_W)
    ) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .load_val (base_value),
        .base     (base_q)
    );

    // translator slots: 0 and 1 are reads, the last is the write
    logic [NUM_XL-1:0][SPEC_W-1:0] xl_spec;
    logic [NUM_XL-1:0][PHYS_W-1:0] xl_phys;
    logic [NUM_XL-1:0]             xl_hit;

    assign xl_spec = {wr_spec, rd1_spec, rd0_spec};

    for (genvar g = 0; g < NUM_XL; g++) begin : g_xl
        rrf_xlate #(
            .ROT_REGS   (ROT_REGS),
            .TOTAL_REGS (TOTAL_REGS),
            .SPEC_W     (SPEC_W),
            .PHYS_W     (PHYS_W),
            .ROT_W      (ROT_W)
        ) u_xl (
            .spec (xl_spec[g]),
            .base (base_q),
            .phys (xl_phys[g]),
            .hit  (xl_hit[g])
        );
    end

    logic [NUM_RD-1:0][PHYS_W-1:0] rd_addr;
    logic [NUM_RD-1:0]             rd_en;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

    assign rd_addr = {xl_phys[1], xl_phys[0]};
    assign rd_en   = xl_hit[NUM_RD-1:0];

    rrf_storage #(
        .DATA_W   (DATA_W),
        .NUM_PHYS (TOTAL_REGS),
        .PHYS_W   (PHYS_W),
        .NUM_RD   (NUM_RD)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && xl_hit[NUM_XL-1]),
        .wr_addr (xl_phys[NUM_XL-1]),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign rd0_data = rd_data[0];
    assign rd1_data = rd_data[1];
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker #(
    parameter int DATA_W     = 16,
    parameter int ROT_REGS   = 16,
    parameter int TOTAL_REGS = 24,
    parameter int SPEC_W     = 5,
    parameter int ROT_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SPEC_W-1:0] rd0_spec,
    input logic [DATA_W-1:0] rd0_data,
    input logic [SPEC_W-1:0] rd1_spec,
    input logic [DATA_W-1:0] rd1_data,
    input logic              wr_en,
    input logic [SPEC_W-1:0] wr_spec,
    input logic [DATA_W-1:0] wr_data,
    input logic              rot_step,
    input logic              base_load,
    input logic [ROT_W-1:0]  base_value,
    input logic [ROT_W-1:0]  base_q
);
    p_base_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(base_q) < 32'(ROT_REGS));

    p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_step && !base_load) |=>
        (32'(base_q) == (($past(base_q) == '0) ? 32'(ROT_REGS - 1)
                                              : 32'($past(base_q)) - 32'd1)));

    p_load_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        base_load |=> (32'(base_q) == (32'($past(base_value)) % 32'(ROT_REGS))));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_load && !rot_step) |=> $stable(base_q));

    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_spec == rd0_spec) && (32'(wr_spec) < 32'(TOTAL_REGS)))
        |-> (rd0_data == wr_data));

    p_oob_rd0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd0_spec) >= 32'(TOTAL_REGS)) |-> (rd0_data == '0));

    p_oob_rd1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd1_spec) >= 32'(TOTAL_REGS)) |-> (rd1_data == '0));
endmodule

bind rotating_regfile rrf_checker #(
    .DATA_W     (DATA_W),
    .ROT_REGS   (ROT_REGS),
    .TOTAL_REGS (ROT_REGS + STAT_REGS),
    .SPEC_W     (SPEC_W),
    .ROT_W      (ROT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd0_spec   (rd0_spec),
    .rd0_data   (rd0_data),
    .rd1_spec   (rd1_spec),
    .rd1_data   (rd1_data),
    .wr_en      (wr_en),
    .wr_spec    (wr_spec),
    .wr_data    (wr_data),
    .rot_step   (rot_step),
    .base_load  (base_load),
    .base_value (base_value),
    .base_q     (base_q)
);

// File: tb/rotating_regfile_tb.sv
module rotating_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int ROT_REGS   = 16;
    localparam int STAT_REGS  = 8;
    localparam int TOTAL      = ROT_REGS + STAT_REGS;
    localparam int SPEC_W     = 5;
    localparam int ROT_W      = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SPEC_W-1:0] rd0_spec = '0, rd1_spec = '0, wr_spec = '0;
    logic [DATA_W-1:0] rd0_data, rd1_data, wr_data = '0;
    logic              wr_en = 1'b0, rot_step = 1'b0, base_load = 1'b0;
    logic [ROT_W-1:0]  base_value = '0;

    int checks = 0;
    int errors = 0;
    int m_base = 0;
    int m_regs [TOTAL];
    logic [DATA_W-1:0] got0, got1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rotating_regfile #(
        .DATA_W(DATA_W), .ROT_REGS(ROT_REGS), .STAT_REGS(STAT_REGS),
        .SPEC_W(SPEC_W), .ROT_W(ROT_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_spec(rd0_spec), .rd0_data(rd0_data),
        .rd1_spec(rd1_spec), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
        .rot_step(rot_step), .base_load(base_load), .base_value(base_value)
    );

    function automatic int phys_of(int s, int b);
        if (s < ROT_REGS) return (s + b) % ROT_REGS;
        return s;
    endfunction

    function automatic string tag_of(int s);
        if (s >= TOTAL) return "R8";
        if (s >= ROT_REGS) return "R3";
        return "R2";
    endfunction

    function automatic int expect_rd(int rs, int we, int ws, int wd);
        if (rs >= TOTAL) return 0;
        if (we != 0 && ws < TOTAL && phys_of(ws, m_base) == phys_of(rs, m_base))
            return wd;
        return m_regs[phys_of(rs, m_base)];
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // one cycle: drive after negedge, check combinational reads, clock, update model
    task automatic cyc(input int r0, input int r1, input int we, input int ws,
                       input int wd, input int st, input int ld, input int lv,
                       input string tag);
        int e0, e1;
        rd0_spec = SPEC_W'(r0); rd1_spec = SPEC_W'(r1);
        wr_en = (we != 0); wr_spec = SPEC_W'(ws); wr_data = DATA_W'(wd);
        rot_step = (st != 0); base_load = (ld != 0); base_value = ROT_W'(lv);
        #1;
        e0 = expect_rd(r0, we, ws, wd);
        e1 = expect_rd(r1, we, ws, wd);
        got0 = rd0_data; got1 = rd1_data;
        check(int'(rd0_data), e0, (tag == "") ? tag_of(r0) : tag);
        check(int'(rd1_data), e1, (tag == "") ? tag_of(r1) : tag);
        @(posedge clk);
        if (we != 0 && ws < TOTAL) m_regs[phys_of(ws, m_base)] = wd;
        if (ld != 0) m_base = lv % ROT_REGS;
        else if (st != 0) m_base = (m_base == 0) ? ROT_REGS - 1 : m_base - 1;
        @(negedge clk);
        wr_en = 1'b0; rot_step = 1'b0; base_load = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < TOTAL; i++) m_regs[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register zero after reset, base zero
        for (int s = 0; s < TOTAL; s += 2) cyc(s, s + 1, 0, 0, 0, 0, 0, 0, "R1");

        // R2: base 3, logical 1 lands in physical 4
        cyc(0, 0, 0, 0, 0, 0, 1, 3, "R7");
        cyc(1, 1, 1, 1, 'h1111, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R7");
        cyc(4, 1, 0, 0, 0, 0, 0, 0, "R2");
        check(int'(got0), 'h1111, "R2");

        // R4: written at 2, seen at 3 after a step
        cyc(0, 0, 1, 2, 'h2222, 0, 0, 0, "");
        cyc(0, 0, 0, 0, 0, 1, 0, 0, "");
        cyc(3, 2, 0, 0, 0, 0, 0, 0, "R4");
        check(int'(got0), 'h2222, "R4");
        // R4: wrap of the base past zero and of the specifier past the top
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R7");
        cyc(0, 0, 1, ROT_REGS - 1, 'h3333, 0, 0, 0, "");
        cyc(0, 0, 0, 0, 0, 1, 0, 0, "");
        cyc(0, ROT_REGS - 1, 0, 0, 0, 0, 0, 0, "R4");
        check(int'(got0), 'h3333, "R4");

        // R5: write during the step uses the old base (0)
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "R7");
        cyc(5, 5, 1, 5, 'h5555, 1, 0, 0, "R5");
        cyc(6, 5, 0, 0, 0, 0, 0, 0, "R5");
        check(int'(got0), 'h5555, "R5");

        // R6: bypass on a fixed register and on a rotating one
        cyc(20, 3, 1, 20, 'h6666, 0, 0, 0, "R6");
        check(int'(got0), 'h6666, "R6");
        cyc(9, 9, 1, 9, 'h6767, 0, 0, 0, "R6");
        check(int'(got1), 'h6767, "R6");

        // R7: load wins over step
        cyc(0, 0, 0, 0, 0, 1, 1, 7, "R7");
        cyc(0, 0, 1, 0, 'h7777, 0, 0, 0, "");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, "");
        cyc(7, 0, 0, 0, 0, 0, 0, 0, "R7");
        check(int'(got0), 'h7777, "R7");

        // R3: fixed register unmoved by rotation
        cyc(0, 0, 1, 18, 'h1818, 0, 0, 0, "");
        for (int k = 0; k < 5; k++) cyc(18, 17, 0, 0, 0, 1, 0, 0, "R3");
        check(int'(got0), 'h1818, "R3");

        // R8: out-of-range write touches nothing; read returns zero
        cyc(30, 31, 1, 30, 'hBEEF, 0, 0, 0, "R8");
        check(int'(got0), 0, "R8");
        for (int s = 0; s < TOTAL; s += 2) cyc(s, s + 1, 0, 0, 0, 0, 0, 0, "R8");

        // random traffic, model compare
        for (int n = 0; n < 3000; n++) begin
            int r0, r1, ws, we, st, ld;
            r0 = int'($urandom_range(0, 31));
            r1 = int'($urandom_range(0, 31));
            ws = ($urandom_range(0, 3) == 0) ? r0 : int'($urandom_range(0, 31));
            we = int'($urandom_range(0, 1));
            st = ($urandom_range(0, 3) == 0) ? 1 : 0;
            ld = ($urandom_range(0, 15) == 0) ? 1 : 0;
            cyc(r0, r1, we, ws, int'($urandom_range(0, 65535)), st, ld,
                int'($urandom_range(0, ROT_REGS - 1)), "");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule